// File: doc/BRIEF.md
# Write Fence Insertion Controller

This block sits in an accelerator's memory request path and places ordering fences at precomputed points in the write stream. A table of write ordinal numbers, sorted in ascending order, is loaded before the run starts. Ordinal n names the n-th write completed since the run began. A 32-bit counter tallies write-completion pulses. When the counter reaches the table entry under the read pointer, a small state machine raises a fence request. It then waits for the memory system's fence response and moves the pointer on by one.

From the moment the trigger condition is seen until the fence has completed and the pointer has advanced, the accelerator's request stream is held off. The pass-through valid/ready pair is forced closed, so no new request can enter the memory system across the fence. When the table is used up, no further fences are raised and traffic flows freely. A start pulse clears the counter, rewinds the pointer and latches the number of valid table entries.

Top module: `wfi_fence_ctrl`

## Requirements
- R1: After reset no fence request is raised, the pointer is at entry 0 and the number of valid entries is 0, so requests pass straight through.
- R2: While `tbl_ld_en` is high, `tbl_ld_data` is stored at table slot `tbl_ld_addr` at the clock edge. A `start` pulse latches `tbl_len`, clamped to `DEPTH`, as the count of valid entries starting at slot 0.
- R3: Each cycle with `wr_done` high raises the write count by one. A `start` pulse clears the count to 0, and a `start` pulse wins over a `wr_done` pulse in the same cycle.
- R4: In the idle state, when the pointer is below the valid-entry count and the write count is at or above the entry under the pointer, the trigger fires. `fence_req_valid` rises in the following cycle.
- R5: `fence_req_valid` stays high until a cycle in which `fence_req_ready` is also high.
- R6: After the fence request is accepted, `fence_req_valid` is low and the controller waits for a `fence_rsp_valid` pulse.
- R7: In the trigger cycle and in every cycle until the controller is idle again, `mem_req_valid` and `acc_req_ready` are 0. In all other cycles `mem_req_valid` equals `acc_req_valid` and `acc_req_ready` equals `mem_req_ready`. `mem_req_data` always equals `acc_req_data`.
- R8: The cycle after a fence response, the pointer advances by one. If the write count is already at or above the new entry, the next fence request is raised in the cycle after that with no idle cycle between.
- R9: Once every valid entry has been consumed, no further fence request is raised, whatever the number of later writes.
- R10: A `fence_rsp_valid` pulse that arrives while no fence is awaiting its response has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears write count and pointer, latches valid-entry count |
| tbl_len | input | $clog2(DEPTH)+1 | Number of valid table entries, taken on `start` |
| tbl_ld_en | input | 1 | Table load strobe |
| tbl_ld_addr | input | $clog2(DEPTH) | Table slot to load |
| tbl_ld_data | input | CW | Write ordinal to store |
| wr_done | input | 1 | One pulse per completed write |
| acc_req_valid | input | 1 | Accelerator request valid |
| acc_req_ready | output | 1 | Ready back to the accelerator |
| acc_req_data | input | DW | Accelerator request payload |
| mem_req_valid | output | 1 | Request valid toward memory |
| mem_req_ready | input | 1 | Memory ready for a request |
| mem_req_data | output | DW | Request payload toward memory |
| fence_req_valid | output | 1 | Fence request valid |
| fence_req_ready | input | 1 | Fence request accepted |
| fence_rsp_valid | input | 1 | Fence completion pulse |

## Verification
The write stream is driven in several patterns. Isolated pulses that stop one short of an entry show whether the comparison is off by one. A `start` in the middle of a count shows whether the count really clears. Writes that keep completing while a fence is outstanding push the count past two further entries, which separates a controller that chains fences back to back from one that idles or loses a crossed entry. A fence handshake held off for several cycles, a stray response while idle, and a long write run after the last entry exercise the hold, ignore and exhaustion rules. Throughout all of this, the gating of the request pass-through is compared with a behavioural model on every cycle.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_WAIT  = 2'd2,
        FS_DONE  = 2'd3
    } fence_state_e;

endpackage

// File: rtl/wfi_ordinal_table.sv
module wfi_ordinal_table #(
    parameter int DEPTH = 256,
    parameter int CW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_data,
    input  logic [AW-1:0] rd_cur_idx,
    output logic [CW-1:0] rd_cur_data,
    input  logic [AW-1:0] rd_nxt_idx,
    output logic [CW-1:0] rd_nxt_data
);

    logic [CW-1:0] slot_q [DEPTH];

    // Table storage: written only through the load port, no reset needed.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            slot_q[ld_addr] <= ld_data;
        end
    end

    // Two read ports: the entry under the pointer and the one after it.
    always_comb begin
        rd_cur_data = slot_q[rd_cur_idx];
        rd_nxt_data = slot_q[rd_nxt_idx];
    end

endmodule

// File: rtl/wfi_write_counter.sv
module wfi_write_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] count
);

    logic [CW-1:0] count_d;
    logic [CW-1:0] count_q;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (inc) begin
            count_d = count_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |=> (count_q == $past(count_q) + CW'(1)));

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0));

endmodule

// File: rtl/wfi_fence_fsm.sv
module wfi_fence_fsm
    import wfi_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] len_in,
    input  logic [CW-1:0] wr_count,
    input  logic [CW-1:0] entry_cur,
    input  logic [CW-1:0] entry_nxt,
    output logic [AW-1:0] rd_cur_idx,
    output logic [AW-1:0] rd_nxt_idx,
    output logic          fence_req_valid,
    input  logic          fence_req_ready,
    input  logic          fence_rsp_valid,
    output logic          stall
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        fence_state_e  state;
        logic [PW-1:0] ptr;
        logic [PW-1:0] len;
    } fsm_regs_t;

    fsm_regs_t r_d;
    fsm_regs_t r_q;

    logic [PW-1:0] ptr_inc;
    logic          have_cur;
    logic          have_nxt;
    logic          trig;

    always_comb begin
        ptr_inc  = r_q.ptr + PW'(1);
        have_cur = (r_q.ptr < r_q.len);
        have_nxt = (ptr_inc < r_q.len);
        trig     = (r_q.state == FS_IDLE) && have_cur && (wr_count >= entry_cur);

        r_d = r_q;
        if (start) begin
            r_d.state = FS_IDLE;
            r_d.ptr   = '0;
            r_d.len   = (len_in > DEPTH_P) ? DEPTH_P : len_in;
        end else begin
            unique case (r_q.state)
                FS_IDLE: begin
                    if (trig) begin
                        r_d.state = FS_ISSUE;
                    end
                end
                FS_ISSUE: begin
                    if (fence_req_ready) begin
                        r_d.state = FS_WAIT;
                    end
                end
                FS_WAIT: begin
                    if (fence_rsp_valid) begin
                        r_d.state = FS_DONE;
                    end
                end
                FS_DONE: begin
                    r_d.ptr = ptr_inc;
                    if (have_nxt && (wr_count >= entry_nxt)) begin
                        r_d.state = FS_ISSUE;
                    end else begin
                        r_d.state = FS_IDLE;
                    end
                end
                default: r_d.state = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= FS_IDLE;
            r_q.ptr   <= '0;
            r_q.len   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_cur_idx      = r_q.ptr[AW-1:0];
    assign rd_nxt_idx      = r_q.ptr[AW-1:0] + AW'(1);
    assign fence_req_valid = (r_q.state == FS_ISSUE);
    assign stall           = (r_q.state != FS_IDLE) || trig;

    // R5: an unaccepted fence request is held
    a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req_valid && !fence_req_ready && !start) |=> fence_req_valid);

    // R6: after acceptance the request drops and traffic stays held
    a_r6_wait_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req_valid && fence_req_ready && !start) |=> (!fence_req_valid && stall));

    // R8: the completion step advances the pointer by exactly one
    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == FS_DONE && !start) |=> (r_q.ptr == $past(r_q.ptr) + PW'(1)));

    // R9: the pointer never runs past the valid entries
    a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ptr <= r_q.len);

    // R10: a response outside the wait state does not move the machine
    a_r10_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == FS_IDLE && fence_rsp_valid && !start && !trig) |=> (r_q.state == FS_IDLE));

endmodule

// File: rtl/wfi_fence_ctrl.sv
module wfi_fence_ctrl #(
    parameter int DEPTH = 256,
    parameter int CW    = 32,
    parameter int DW    = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] tbl_len,
    input  logic          tbl_ld_en,
    input  logic [AW-1:0] tbl_ld_addr,
    input  logic [CW-1:0] tbl_ld_data,
    input  logic          wr_done,
    input  logic          acc_req_valid,
    output logic          acc_req_ready,
    input  logic [DW-1:0] acc_req_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [DW-1:0] mem_req_data,
    output logic          fence_req_valid,
    input  logic          fence_req_ready,
    input  logic          fence_rsp_valid
);

    logic [CW-1:0] wr_count;
    logic [CW-1:0] entry_cur;
    logic [CW-1:0] entry_nxt;
    logic [AW-1:0] rd_cur_idx;
    logic [AW-1:0] rd_nxt_idx;
    logic          stall;

    wfi_ordinal_table #(.DEPTH(DEPTH), .CW(CW)) u_table (
        .clk         (clk),
        .ld_en       (tbl_ld_en),
        .ld_addr     (tbl_ld_addr),
        .ld_data     (tbl_ld_data),
        .rd_cur_idx  (rd_cur_idx),
        .rd_cur_data (entry_cur),
        .rd_nxt_idx  (rd_nxt_idx),
        .rd_nxt_data (entry_nxt)
    );

    wfi_write_counter #(.CW(CW)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .inc   (wr_done),
        .count (wr_count)
    );

    wfi_fence_fsm #(.DEPTH(DEPTH), .CW(CW)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .len_in          (tbl_len),
        .wr_count        (wr_count),
        .entry_cur       (entry_cur),
        .entry_nxt       (entry_nxt),
        .rd_cur_idx      (rd_cur_idx),
        .rd_nxt_idx      (rd_nxt_idx),
        .fence_req_valid (fence_req_valid),
        .fence_req_ready (fence_req_ready),
        .fence_rsp_valid (fence_rsp_valid),
        .stall           (stall)
    );

    // Request pass-through, closed while a fence is pending.
    always_comb begin
        mem_req_valid = acc_req_valid && !stall;
        acc_req_ready = mem_req_ready && !stall;
        mem_req_data  = acc_req_data;
    end

    // R7: no request enters memory while the fence is being offered
    a_r7_gate_on_fence: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req_valid |-> (!mem_req_valid && !acc_req_ready));

endmodule

// File: tb/test_wfi_fence_ctrl.sv
module test_wfi_fence_ctrl;

    localparam int DEPTH = 256;
    localparam int CW    = 32;
    localparam int DW    = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] tbl_len = '0;
    logic          tbl_ld_en = 1'b0;
    logic [AW-1:0] tbl_ld_addr = '0;
    logic [CW-1:0] tbl_ld_data = '0;
    logic          wr_done = 1'b0;
    logic          acc_req_valid = 1'b0;
    logic          acc_req_ready;
    logic [DW-1:0] acc_req_data = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [DW-1:0] mem_req_data;
    logic          fence_req_valid;
    logic          fence_req_ready = 1'b0;
    logic          fence_rsp_valid = 1'b0;

    always #4 clk = ~clk;

    wfi_fence_ctrl #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) i_wfi_fence_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .tbl_len         (tbl_len),
        .tbl_ld_en       (tbl_ld_en),
        .tbl_ld_addr     (tbl_ld_addr),
        .tbl_ld_data     (tbl_ld_data),
        .wr_done         (wr_done),
        .acc_req_valid   (acc_req_valid),
        .acc_req_ready   (acc_req_ready),
        .acc_req_data    (acc_req_data),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_data    (mem_req_data),
        .fence_req_valid (fence_req_valid),
        .fence_req_ready (fence_req_ready),
        .fence_rsp_valid (fence_rsp_valid)
    );

    int n_cmp  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int fences_seen = 0;

    // Behavioural reference: phase 0 idle, 1 offering, 2 awaiting, 3 completing
    longint m_cnt = 0;
    int     m_ptr = 0;
    int     m_len = 0;
    int     m_phase = 0;
    longint m_tbl [DEPTH];

    function automatic bit m_trig();
        return (m_phase == 0) && (m_ptr < m_len) && (m_cnt >= m_tbl[m_ptr]);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic settle();
        bit st;
        @(negedge clk);
        st = (m_phase != 0) || m_trig();
        chk("R4 fence_req_valid vs model", longint'(fence_req_valid), longint'(m_phase == 1));
        chk("R7 mem_req_valid vs model", longint'(mem_req_valid), longint'(acc_req_valid && !st));
        chk("R7 acc_req_ready vs model", longint'(acc_req_ready), longint'(mem_req_ready && !st));
        chk("R7 payload pass-through", longint'(mem_req_data), longint'(acc_req_data));
        if (fence_req_valid && fence_req_ready) fences_seen++;
    endtask

    task automatic adv();
        longint old_cnt;
        bit     tr;
        @(posedge clk);
        old_cnt = m_cnt;
        tr = m_trig();
        if (!rst_n) begin
            m_cnt = 0; m_ptr = 0; m_len = 0; m_phase = 0;
        end else if (start) begin
            m_cnt = 0; m_ptr = 0; m_phase = 0;
            m_len = (int'(tbl_len) > DEPTH) ? DEPTH : int'(tbl_len);
        end else begin
            case (m_phase)
                0: if (tr) m_phase = 1;
                1: if (fence_req_ready) m_phase = 2;
                2: if (fence_rsp_valid) m_phase = 3;
                default: begin
                    m_ptr++;
                    m_phase = ((m_ptr < m_len) && (old_cnt >= m_tbl[m_ptr])) ? 1 : 0;
                end
            endcase
            if (wr_done) m_cnt = (m_cnt + 1) % (64'd1 << CW);
        end
        if (tbl_ld_en) m_tbl[tbl_ld_addr] = longint'(tbl_ld_data);
        #1;
        acc_req_data = acc_req_data + 64'h0001_0000_0000_0003;
    endtask

    task automatic tick();
        settle();
        adv();
    endtask

    task automatic load(input int addr, input int val);
        tbl_ld_en = 1'b1; tbl_ld_addr = AW'(addr); tbl_ld_data = CW'(val);
        tick();
        tbl_ld_en = 1'b0;
    endtask

    task automatic pulse_start(input int len);
        start = 1'b1; tbl_len = PW'(len);
        tick();
        start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        bit got;
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = 0;
        acc_req_valid = 1'b1;
        mem_req_ready = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;

        // R1: reset state, traffic open and no fence
        settle();
        chk("R1 fence idle after reset", longint'(fence_req_valid), 0);
        chk("R1 pass-through open after reset", longint'(mem_req_valid), 1);
        adv();

        // R2: load ordinals 3, 5, 6, 10
        load(0, 3); load(1, 5); load(2, 6); load(3, 10);
        pulse_start(4);

        // R3: two writes, then restart clears the count
        wr_done = 1'b1; tick(); tick(); wr_done = 1'b0;
        repeat (3) begin
            settle();
            chk("R3 no fence below ordinal", longint'(fence_req_valid), 0);
            adv();
        end
        start = 1'b1; wr_done = 1'b1; tbl_len = PW'(4); tick();
        start = 1'b0;
        tick(); tick(); wr_done = 1'b0;
        repeat (3) begin
            settle();
            chk("R3 count cleared by start", longint'(fence_req_valid), 0);
            chk("R3 traffic open", longint'(acc_req_ready), 1);
            adv();
        end

        // R4: third write reaches ordinal 3
        wr_done = 1'b1; tick(); wr_done = 1'b0;
        settle();
        chk("R4 stall in trigger cycle", longint'(mem_req_valid), 0);
        adv();
        settle();
        chk("R4 fence raised", longint'(fence_req_valid), 1);
        adv();

        // R5: request held while not accepted
        mem_req_ready = 1'b0;
        repeat (4) begin
            settle();
            chk("R5 fence held", longint'(fence_req_valid), 1);
            adv();
        end
        mem_req_ready = 1'b1;
        fence_req_ready = 1'b1; tick(); fence_req_ready = 1'b0;

        // R6: awaiting response while writes continue (count reaches 6)
        for (int k = 0; k < 4; k++) begin
            wr_done = (k < 3);
            settle();
            chk("R6 no request while awaiting", longint'(fence_req_valid), 0);
            chk("R6 traffic held while awaiting", longint'(acc_req_ready), 0);
            adv();
        end
        wr_done = 1'b0;

        // R8: chained fences for ordinals 5 and 6
        for (int f = 0; f < 2; f++) begin
            fence_rsp_valid = 1'b1; tick(); fence_rsp_valid = 1'b0;
            settle();
            chk("R8 completion cycle", longint'(fence_req_valid), 0);
            chk("R8 held in completion", longint'(mem_req_valid), 0);
            adv();
            settle();
            chk("R8 back-to-back fence", longint'(fence_req_valid), 1);
            adv();
            fence_req_ready = 1'b1; tick(); fence_req_ready = 1'b0;
        end
        fence_rsp_valid = 1'b1; tick(); fence_rsp_valid = 1'b0;
        tick();
        settle();
        chk("R7 traffic reopened after fence", longint'(mem_req_valid), 1);
        chk("R7 fence idle below ordinal 10", longint'(fence_req_valid), 0);
        adv();

        // R10: stray response while idle
        fence_rsp_valid = 1'b1; tick(); fence_rsp_valid = 1'b0;
        repeat (2) begin
            settle();
            chk("R10 stray response ignored", longint'(fence_req_valid), 0);
            chk("R10 traffic still open", longint'(acc_req_ready), 1);
            adv();
        end

        // Writes 7..10 reach last ordinal; accept with ready held high
        wr_done = 1'b1; repeat (4) tick(); wr_done = 1'b0;
        fence_req_ready = 1'b1;
        got = 1'b0;
        for (int i = 0; i < 4; i++) begin
            settle();
            if (fence_req_valid) got = 1'b1;
            adv();
        end
        fence_req_ready = 1'b0;
        chk("R4 fence at last ordinal", longint'(got), 1);
        fence_rsp_valid = 1'b1; tick(); fence_rsp_valid = 1'b0;
        tick();

        // R9: table exhausted
        wr_done = 1'b1;
        repeat (20) begin
            settle();
            chk("R9 no fence after table used", longint'(fence_req_valid), 0);
            adv();
        end
        wr_done = 1'b0;
        chk("R9 total fences accepted", longint'(fences_seen), 4);

        // R2: restart with a reloaded single-entry table at ordinal 1
        load(0, 1);
        pulse_start(1);
        wr_done = 1'b1; tick(); wr_done = 1'b0;
        tick();
        settle();
        chk("R2 reloaded entry triggers", longint'(fence_req_valid), 1);
        adv();
        fence_req_ready = 1'b1; tick(); fence_req_ready = 1'b0;
        fence_rsp_valid = 1'b1; tick(); fence_rsp_valid = 1'b0;
        repeat (3) tick();

        finish_run();
    end

endmodule